// File: doc/BRIEF.md
# Vector Length Setting Unit

This block keeps the two length registers of a vector pipeline: the maximum vector length (MVL) and the active vector length (VL). Each instruction that carries a 12-bit length-control field presents that field together with an enable. The block decodes the field. It then either leaves both lengths alone, or it loads a new MVL from an immediate and sets VL from that MVL. VL becomes the MVL itself, or the smaller of the MVL and a count read from a general register. It can also return the resulting VL to a general register through a write port.

The field has two layouts, chosen by bit 11. The compact layout names registers with 3-bit codes, where code 0 means "no register". The full layout names one register with a 5-bit number, and bit 5 says whether that register is a destination or a source. Both lengths are held in 6 bits. A stored 0 stands for 64, so the lengths read as 1 to 64. The register file is outside the block. The block drives a read address and expects the read data back in the same cycle.

Top module: `vlen_unit`

## Requirements
- R1: For every accepted operation other than the no-op, MVL takes the 5-bit immediate in field bits 10:6. An immediate of 0 gives MVL = 64. The new MVL is visible on `mvl` in the cycle after the enable.
- R2: A field of all zeros (bit 11 = 0 and bits 10:0 = 0) with `en` high leaves `vl` and `mvl` unchanged, and it raises neither `wr_en` nor `illegal`.
- R3: With bit 11 = 0, bits 5:3 are a destination code and bits 2:0 are a source code. A nonzero code c selects register x(8+c). Code 0 means the slot is unused.
- R4: When a source is used, `rs_addr` shows that register while `en` is high, and the new VL is the smaller of the register value and the new MVL.
- R5: When no source is used, the new VL equals the new MVL.
- R6: When a destination is used, `wr_en` pulses for exactly one cycle, together with the new VL. `wr_addr` is the destination and `wr_data` is the new VL as a value from 1 to 64.
- R7: With bit 11 = 1 and bit 5 = 0, bits 4:0 give a full destination register number. Register 0 means MVL and VL are set and nothing is written.
- R8: With bit 11 = 1 and bit 5 = 1, bits 4:0 give a full source register number. Register 0 is reserved: `illegal` pulses for one cycle, MVL and VL do not change, and nothing is written.
- R9: A source count of 0 is read as the maximum, so VL = MVL. Any count at or above MVL, including counts above 63, gives VL = MVL.
- R10: After reset, `vl` = 64, `mvl` = 64, and `wr_en` and `illegal` are low.
- R11: While `en` is low, `vl` and `mvl` hold, and `wr_en` and `illegal` stay low whatever the field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Execute the field this cycle |
| ctl | input | 12 | Length-control field |
| rs_addr | output | 5 | Source register read address (0 when no source) |
| rs_data | input | XLEN | Read data for `rs_addr`, same cycle |
| vl | output | 7 | Active vector length, 1..64 |
| mvl | output | 7 | Maximum vector length, 1..64 |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 5 | Register write address |
| wr_data | output | XLEN | Register write data (new VL) |
| illegal | output | 1 | Reserved encoding seen |

## Verification
The read address `rs_addr` is combinational, so the bench checks it in the same cycle as the enable, after the inputs settle. All other results come from a single register stage. `vl`, `mvl`, the write port and `illegal` therefore change at the first rising edge after the enable. The bench drives each stimulus at a falling edge and holds it for one cycle. It samples the results at the next falling edge, which is the only window in which the one-cycle pulses of `wr_en` and `illegal` can be seen. Hold checks for the no-op, reserved and idle cases read `vl` and `mvl` in that same window, against the values left by the previous operation.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

    // Stored width of each length register; 0 encodes the maximum.
    localparam int LEN_W  = 6;
    // Width of an architectural register number.
    localparam int REG_AW = 5;
    // Width of the immediate MVL field.
    localparam int IMM_W  = 5;
    // Width of a compact register code.
    localparam int CREG_W = 3;
    // Width of the whole control field.
    localparam int CTL_W  = 12;

    // Decoded view of one control field.
    typedef struct packed {
        logic              nop;
        logic              rsvd;
        logic [LEN_W-1:0]  mvl_enc;
        logic              src_use;
        logic [REG_AW-1:0] src_reg;
        logic              dst_use;
        logic [REG_AW-1:0] dst_reg;
    } vl_op_t;

    // Registered state of the unit.
    typedef struct packed {
        logic [LEN_W-1:0]  mvl;
        logic [LEN_W-1:0]  vl;
        logic              we;
        logic [REG_AW-1:0] wa;
        logic [LEN_W:0]    wd;
        logic              ill;
    } vl_state_t;

    // Stored encoding to length value: 0 reads as 2**LEN_W.
    function automatic logic [LEN_W:0] enc2val(input logic [LEN_W-1:0] e);
        if (e == '0) begin
            return {1'b1, {LEN_W{1'b0}}};
        end
        return {1'b0, e};
    endfunction

endpackage

// File: rtl/vlen_decode.sv
module vlen_decode
    import vlen_pkg::*;
#(
    parameter int CREG_BASE = 8
) (
    input  logic [CTL_W-1:0] ctl,
    output vl_op_t           op
);

    localparam int IMM_LSB = 6;
    localparam int FMT_BIT = 11;
    localparam int DIR_BIT = 5;

    logic             full_fmt;
    logic [IMM_W-1:0] imm;
    logic [CREG_W-1:0] c_dst;
    logic [CREG_W-1:0] c_src;
    logic [REG_AW-1:0] f_reg;
    logic             f_is_src;

    assign full_fmt = ctl[FMT_BIT];
    assign imm      = ctl[IMM_LSB +: IMM_W];
    assign c_dst    = ctl[CREG_W +: CREG_W];
    assign c_src    = ctl[0 +: CREG_W];
    assign f_reg    = ctl[0 +: REG_AW];
    assign f_is_src = ctl[DIR_BIT];

    // Map a nonzero compact code onto the compact register window.
    function automatic logic [REG_AW-1:0] cmap(input logic [CREG_W-1:0] c);
        return REG_AW'(CREG_BASE) + REG_AW'(c);
    endfunction

    always_comb begin
        op         = '0;
        op.mvl_enc = LEN_W'(imm);
        if (!full_fmt) begin
            op.nop     = (ctl[FMT_BIT-1:0] == '0);
            op.src_use = (c_src != '0) && !op.nop;
            op.dst_use = (c_dst != '0) && !op.nop;
            op.src_reg = op.src_use ? cmap(c_src) : '0;
            op.dst_reg = op.dst_use ? cmap(c_dst) : '0;
        end else if (f_is_src) begin
            op.rsvd    = (f_reg == '0);
            op.src_use = (f_reg != '0);
            op.src_reg = f_reg;
        end else begin
            op.dst_use = (f_reg != '0);
            op.dst_reg = f_reg;
        end
    end

endmodule

// File: rtl/vlen_clamp.sv
module vlen_clamp
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  count,
    input  logic [LEN_W-1:0] mvl_enc,
    output logic [LEN_W-1:0] vl_enc
);

    logic [LEN_W:0] mvl_val;
    logic           hi_set;
    logic           over;

    assign mvl_val = enc2val(mvl_enc);

    // Any bit above the length range forces the count past every MVL.
    generate
        if (XLEN > LEN_W + 1) begin : g_wide
            assign hi_set = |count[XLEN-1:LEN_W+1];
        end else begin : g_narrow
            assign hi_set = 1'b0;
        end
    endgenerate

    assign over = hi_set || (count[LEN_W:0] >= mvl_val);

    // Zero count stands for the maximum, so it also yields MVL.
    always_comb begin
        if (count == '0 || over) begin
            vl_enc = mvl_enc;
        end else begin
            vl_enc = count[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/vlen_unit.sv
module vlen_unit
    import vlen_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CREG_BASE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CTL_W-1:0]  ctl,
    output logic [REG_AW-1:0] rs_addr,
    input  logic [XLEN-1:0]   rs_data,
    output logic [LEN_W:0]    vl,
    output logic [LEN_W:0]    mvl,
    output logic              wr_en,
    output logic [REG_AW-1:0] wr_addr,
    output logic [XLEN-1:0]   wr_data,
    output logic              illegal
);

    vl_op_t           op;
    vl_state_t        st_d;
    vl_state_t        st_q;
    logic [XLEN-1:0]  count;
    logic [LEN_W-1:0] new_vl;

    vlen_decode #(
        .CREG_BASE(CREG_BASE)
    ) u_dec (
        .ctl(ctl),
        .op (op)
    );

    assign count   = op.src_use ? rs_data : '0;
    assign rs_addr = op.src_reg;

    vlen_clamp #(
        .XLEN(XLEN)
    ) u_clamp (
        .count  (count),
        .mvl_enc(op.mvl_enc),
        .vl_enc (new_vl)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.ill = 1'b0;
        if (en) begin
            if (op.rsvd) begin
                st_d.ill = 1'b1;
            end else if (!op.nop) begin
                st_d.mvl = op.mvl_enc;
                st_d.vl  = new_vl;
                if (op.dst_use) begin
                    st_d.we = 1'b1;
                    st_d.wa = op.dst_reg;
                    st_d.wd = enc2val(new_vl);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl      = enc2val(st_q.vl);
    assign mvl     = enc2val(st_q.mvl);
    assign wr_en   = st_q.we;
    assign wr_addr = st_q.wa;
    assign wr_data = XLEN'(st_q.wd);
    assign illegal = st_q.ill;

endmodule

// File: rtl/vlen_unit_chk.sv
module vlen_unit_chk
    import vlen_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [CTL_W-1:0]  ctl,
    input logic [LEN_W:0]    vl,
    input logic [LEN_W:0]    mvl,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [XLEN-1:0]   wr_data,
    input logic              illegal
);

    localparam logic [LEN_W:0] LMAX = {1'b1, {LEN_W{1'b0}}};

    AST_NOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctl == '0) |=> ($stable(vl) && $stable(mvl) && !wr_en && !illegal)); // R2

    AST_MVL_FROM_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctl != '0 && !(ctl[11] && ctl[5] && ctl[4:0] == '0))
        |=> (mvl == (($past(ctl[10:6]) == '0) ? LMAX : (LEN_W+1)'($past(ctl[10:6]))))); // R1

    AST_VL_WITHIN_MVL: assert property (@(posedge clk) disable iff (!rst_n)
        (vl <= mvl) && (vl != '0) && (mvl <= LMAX)); // R9

    AST_WB_MATCHES_VL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == XLEN'(vl) && wr_addr != '0)); // R6

    AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctl[11] && ctl[5] && ctl[4:0] == '0)
        |=> (illegal && !wr_en && $stable(vl) && $stable(mvl))); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!wr_en && !illegal && $stable(vl) && $stable(mvl))); // R11

    AST_FULL_DST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ctl[11] && !ctl[5] && ctl[4:0] == '0) |=> !wr_en); // R7

endmodule

bind vlen_unit vlen_unit_chk #(
    .XLEN(XLEN)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .ctl    (ctl),
    .vl     (vl),
    .mvl    (mvl),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .illegal(illegal)
);

// File: tb/vlen_unit_test.sv
module vlen_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int XLEN       = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic [11:0]     ctl = '0;
    logic [4:0]      rs_addr;
    logic [XLEN-1:0] rs_data;
    logic [6:0]      vl;
    logic [6:0]      mvl;
    logic            wr_en;
    logic [4:0]      wr_addr;
    logic [XLEN-1:0] wr_data;
    logic            illegal;

    logic [XLEN-1:0] regs [32];

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb rs_data = regs[rs_addr];

    vlen_unit #(.XLEN(XLEN), .CREG_BASE(8)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .ctl(ctl),
        .rs_addr(rs_addr), .rs_data(rs_data),
        .vl(vl), .mvl(mvl), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .illegal(illegal)
    );

    task automatic cmp(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One enabled cycle; results sampled at the following falling edge.
    task automatic run(input string req, input logic [11:0] f,
                       input int e_vl, input int e_mvl, input bit e_we,
                       input int e_wa, input bit e_ill);
        @(negedge clk);
        en  = 1'b1;
        ctl = f;
        @(negedge clk);
        en  = 1'b0;
        ctl = '0;
        cmp(req, "vl", vl, e_vl);
        cmp(req, "mvl", mvl, e_mvl);
        cmp(req, "wr_en", wr_en, e_we);
        cmp(req, "illegal", illegal, e_ill);
        if (e_we) begin
            cmp(req, "wr_addr", wr_addr, e_wa);
            cmp(req, "wr_data", wr_data, e_vl);
        end
    endtask

    task automatic src_addr(input string req, input logic [11:0] f, input int e_addr);
        @(negedge clk);
        ctl = f;
        #1;
        cmp(req, "rs_addr", rs_addr, e_addr);
        ctl = '0;
    endtask

    task automatic t_reset();
        cmp("R10", "vl", vl, 64);
        cmp("R10", "mvl", mvl, 64);
        cmp("R10", "wr_en", wr_en, 0);
        cmp("R10", "illegal", illegal, 0);
    endtask

    task automatic t_imm_only();
        run("R1_R5", 12'h280, 10, 10, 0, 0, 0);
    endtask

    task automatic t_nop();
        run("R2", 12'h000, 10, 10, 0, 0, 0);
    endtask

    task automatic t_compact_src();
        regs[11] = 7;
        src_addr("R3_R4", 12'h503, 11);
        run("R4", 12'h503, 7, 20, 0, 0, 0);
        regs[14] = 8;
        run("R4", 12'h206, 8, 8, 0, 0, 0);
    endtask

    task automatic t_compact_dst();
        regs[13] = 100;
        run("R6_R3", 12'h415, 16, 16, 1, 10, 0);
    endtask

    task automatic t_counts();
        regs[9] = 0;
        run("R9", 12'h301, 12, 12, 0, 0, 0);
        regs[15] = 32'h1234;
        run("R9_R1", 12'h027, 64, 64, 1, 12, 0);
        regs[9] = 30;
        run("R1", 12'h7C1, 30, 31, 0, 0, 0);
    endtask

    task automatic t_full_dst();
        run("R7", 12'h954, 5, 5, 1, 20, 0);
        run("R7", 12'hA40, 9, 9, 0, 0, 0);
    endtask

    task automatic t_full_src();
        regs[17] = 25;
        src_addr("R8", 12'hFB1, 17);
        run("R8", 12'hFB1, 25, 30, 0, 0, 0);
        run("R8", 12'h8E0, 25, 30, 0, 0, 1);
    endtask

    task automatic t_idle();
        @(negedge clk);
        en  = 1'b0;
        ctl = 12'h954;
        @(negedge clk);
        cmp("R11", "vl", vl, 25);
        cmp("R11", "mvl", mvl, 30);
        cmp("R11", "wr_en", wr_en, 0);
        cmp("R11", "illegal", illegal, 0);
        ctl = '0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_imm_only();
        t_nop();
        t_compact_src();
        t_compact_dst();
        t_counts();
        t_full_dst();
        t_full_src();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule